// File: doc/BRIEF.md
# Indexed-Address Register Machine Core

This block is a small processor core with sixteen general registers. It executes one instruction per clock. Every instruction names one destination register. The second operand is either another register or a memory word. A memory word is reached through an effective address, which is a 16-bit offset plus the value of an optional index register.

The core fetches from an instruction port and works on a data port. Both ports are expected to return read data in the same cycle as the address. Stores are committed at the next clock edge through a write strobe.

The core offers:
- register moves and register arithmetic;
- loads, and arithmetic with a memory operand;
- stores;
- signed compares into three condition flags;
- jumps through a register, to an address, or on a flag condition;
- branch-and-link, which leaves the return address in a named register.

Top module: `rm_core`

## Requirements
- R1: While reset is active, and in the first cycle after it, the fetch address is 0, every register reads 0, all flags are clear and no store is issued.
- R2: The instruction word is split into fields as follows. Bits [31:26] are the opcode, [25:22] the destination register, [21:18] the index or second register, [17:16] reserved (must be 0) and [15:0] the offset. The effective address is the zero-extended offset plus the low address bits of the index register.
- R3: An index field of 0 applies no index. The effective address is then the offset alone, whatever R0 holds. R0 is otherwise an ordinary register.
- R4: The register forms update the destination with destination op second register. Opcode 0x01 is move, 0x02 add, 0x03 subtract, 0x04 AND, 0x05 OR and 0x06 XOR.
- R5: The memory forms update the destination with destination op memory word at the effective address. Opcode 0x11 is load, 0x12 add, 0x13 subtract, 0x14 AND, 0x15 OR and 0x16 XOR.
- R6: Opcode 0x22 writes the destination register to the effective address, and changes no register.
- R7: Compares treat both operands as signed. Opcode 0x20 compares against the second register, and 0x21 compares against the memory word. A compare sets exactly one flag: bit 0 for equal, bit 1 for less than, bit 2 for greater than. No other instruction changes the flags.
- R8: Opcode 0x2A jumps to the effective address when any flag selected by the condition mask (bits [24:22]) is set. A mask of 000 never jumps.
- R9: Opcode 0x28 jumps to the address held in the destination register. Opcode 0x29 jumps to the effective address.
- R10: Opcode 0x2B writes the address of the following instruction into the destination register, then jumps to the effective address.
- R11: Every other instruction advances the fetch address by one. This includes any opcode not listed, and any word with nonzero reserved bits. Such words change no register, flag or memory word.
- R12: Each clock completes exactly one instruction. Each store appears once, in program order, with its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | AW | Address of the instruction being executed |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | AW | Effective address of the current instruction |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |
| dmem_wdata | output | 32 | Store data (destination register) |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |

## Verification
The assertions assume that both memory ports return the word for the current address within the same cycle. They also assume that the instruction word is stable for the whole cycle. The stimulus meets this with bench memories that read combinationally and write only on the clock edge. Addresses stay inside their 64 words.

The test program first places a nonzero value in R0. This makes the no-index rule observable, because a wrongly indexed access would pick up a different word. The program also compares against a negative memory word, so an unsigned compare would take a guarded wrong path. Every skipped or never-taken path lands on guard words, which issue an unexpected store.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef logic [31:0] word_t;

  localparam int RM_NREG = 16;
  localparam int RM_IW   = $clog2(RM_NREG);

  typedef enum logic [3:0] {
    CL_NOP, CL_ALU_R, CL_ALU_M, CL_CMP_R, CL_CMP_M,
    CL_STORE, CL_JREG, CL_JABS, CL_JCOND, CL_LINK
  } cls_e;

  // flag bit positions
  localparam int FL_EQ = 0;
  localparam int FL_LT = 1;
  localparam int FL_GT = 2;

  function automatic cls_e rm_class(input logic [5:0] op, input logic [1:0] rsv);
    cls_e c;
    c = CL_NOP;
    if (rsv == 2'b00) begin
      unique case (op[5:4])
        2'b00: c = (op[3] == 1'b0 && op[2:0] inside {[3'd1:3'd6]}) ? CL_ALU_R : CL_NOP;
        2'b01: c = (op[3] == 1'b0 && op[2:0] inside {[3'd1:3'd6]}) ? CL_ALU_M : CL_NOP;
        2'b10: begin
          case (op[3:0])
            4'h0: c = CL_CMP_R;
            4'h1: c = CL_CMP_M;
            4'h2: c = CL_STORE;
            4'h8: c = CL_JREG;
            4'h9: c = CL_JABS;
            4'hA: c = CL_JCOND;
            4'hB: c = CL_LINK;
            default: c = CL_NOP;
          endcase
        end
        default: c = CL_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic word_t rm_alu(input logic [2:0] fn, input word_t a, input word_t b);
    case (fn)
      3'd1: return b;
      3'd2: return a + b;
      3'd3: return a - b;
      3'd4: return a & b;
      3'd5: return a | b;
      3'd6: return a ^ b;
      default: return a;
    endcase
  endfunction

  function automatic logic [2:0] rm_cmp(input word_t a, input word_t b);
    logic [2:0] f;
    f = '0;
    if (a == b)                       f[FL_EQ] = 1'b1;
    else if ($signed(a) < $signed(b)) f[FL_LT] = 1'b1;
    else                              f[FL_GT] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/rm_regfile.sv
module rm_regfile
  import rm_pkg::*;
#(
  parameter int NREG = RM_NREG,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_idx,
  output word_t         ra_val,
  input  logic [IW-1:0] rb_idx,
  output word_t         rb_val,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  word_t         wr_data
);
  word_t regs_q [NREG];

  assign ra_val = regs_q[ra_idx];
  assign rb_val = regs_q[rb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  // R5
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rm_decode.sv
module rm_decode
  import rm_pkg::*;
#(
  parameter int AW = 16
) (
  input  word_t             instr,
  input  logic [AW-1:0]     rx_lo,
  output cls_e              cls,
  output logic [2:0]        fn,
  output logic [RM_IW-1:0]  rd_idx,
  output logic [RM_IW-1:0]  rx_idx,
  output logic [2:0]        cond,
  output logic [AW-1:0]     ea
);
  function automatic logic [AW-1:0] calc_ea(input logic [15:0] off,
                                            input logic [AW-1:0] base,
                                            input logic use_base);
    return AW'(off) + (use_base ? base : '0);
  endfunction

  assign cls    = rm_class(instr[31:26], instr[17:16]);
  assign fn     = instr[28:26];
  assign rd_idx = instr[25:22];
  assign rx_idx = instr[21:18];
  assign cond   = instr[24:22];
  assign ea     = calc_ea(instr[15:0], rx_lo, rx_idx != '0);
endmodule

// File: rtl/rm_ctrl.sv
module rm_ctrl
  import rm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cls_e          cls,
  input  logic [2:0]    cond,
  input  word_t         cmp_a,
  input  word_t         cmp_b,
  input  logic [AW-1:0] ea,
  input  logic [AW-1:0] jr_tgt,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_inc
);
  logic [AW-1:0] pc_q, pc_nx;
  logic [2:0]    flags_q;
  logic          cmp_evt, jc_hit, redirect;

  assign pc      = pc_q;
  assign pc_inc  = pc_q + 1'b1;
  assign cmp_evt = (cls == CL_CMP_R) || (cls == CL_CMP_M);
  assign jc_hit  = (cls == CL_JCOND) && ((cond & flags_q) != 3'b000);

  always_comb begin
    pc_nx    = pc_inc;
    redirect = 1'b0;
    case (cls)
      CL_JREG:          begin pc_nx = jr_tgt; redirect = 1'b1; end
      CL_JABS, CL_LINK: begin pc_nx = ea;     redirect = 1'b1; end
      CL_JCOND: if (jc_hit) begin pc_nx = ea; redirect = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      flags_q <= '0;
    end else begin
      pc_q <= pc_nx;
      if (cmp_evt) flags_q <= rm_cmp(cmp_a, cmp_b);
    end
  end

  // R7
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> $countones(flags_q) == 1);
  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_evt |=> $stable(flags_q));
  // R11
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> pc_q == AW'($past(pc_q) + 1'b1));
  // R8
  jc_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CL_JCOND && cond == 3'b000) |=> pc_q == AW'($past(pc_q) + 1'b1));
endmodule

// File: rtl/rm_core.sv
module rm_core
  import rm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_data,
  output logic [AW-1:0] dmem_addr,
  input  logic [31:0]   dmem_rdata,
  output logic [31:0]   dmem_wdata,
  output logic          dmem_we
);
  cls_e             cls;
  logic [2:0]       fn, cond;
  logic [RM_IW-1:0] rd_idx, rx_idx;
  word_t            rd_val, rx_val, opb, alu_y, wb_data;
  logic [AW-1:0]    ea, pc, pc_inc;
  logic             wb_en, is_link;

  rm_decode #(.AW(AW)) u_dec (
    .instr(imem_data), .rx_lo(rx_val[AW-1:0]), .cls(cls), .fn(fn),
    .rd_idx(rd_idx), .rx_idx(rx_idx), .cond(cond), .ea(ea)
  );

  rm_regfile #(.NREG(RM_NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(rd_idx), .ra_val(rd_val),
    .rb_idx(rx_idx), .rb_val(rx_val),
    .wr_en(wb_en), .wr_idx(rd_idx), .wr_data(wb_data)
  );

  assign opb     = (cls == CL_ALU_M || cls == CL_CMP_M) ? dmem_rdata : rx_val;
  assign alu_y   = rm_alu(fn, rd_val, opb);
  assign is_link = (cls == CL_LINK);
  assign wb_en   = (cls == CL_ALU_R) || (cls == CL_ALU_M) || is_link;
  assign wb_data = is_link ? word_t'(pc_inc) : alu_y;

  rm_ctrl #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cls(cls), .cond(cond),
    .cmp_a(rd_val), .cmp_b(opb), .ea(ea), .jr_tgt(rd_val[AW-1:0]),
    .pc(pc), .pc_inc(pc_inc)
  );

  assign imem_addr  = pc;
  assign dmem_addr  = ea;
  assign dmem_wdata = rd_val;
  assign dmem_we    = (cls == CL_STORE);

  // R3
  no_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_data[21:18] == 4'd0) |-> dmem_addr == AW'(imem_data[15:0]));
  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !wb_en);
  // R10
  link_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_link |=> imem_addr == $past(dmem_addr));
  // R12
  store_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> imem_addr == AW'($past(imem_addr) + 1'b1));
endmodule

// File: tb/test_rm_core.sv
module test_rm_core;
  localparam int AW = 16;

  localparam logic [5:0] K_MOV = 6'h01, K_ADD = 6'h02, K_OR = 6'h05, K_XOR = 6'h06;
  localparam logic [5:0] K_LD = 6'h11, K_SUBM = 6'h13, K_ANDM = 6'h14;
  localparam logic [5:0] K_CMP = 6'h20, K_CMPM = 6'h21, K_ST = 6'h22;
  localparam logic [5:0] K_JR = 6'h28, K_JA = 6'h29, K_JC = 6'h2A, K_BAL = 6'h2B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr, dmem_addr;
  logic [31:0]   imem_data, dmem_rdata, dmem_wdata;
  logic          dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] q_addr [$];
  logic [31:0] q_data [$];
  string       q_tag  [$];

  always #10 clk = ~clk;

  rm_core #(.AW(AW)) i_rm_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we)
  );

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [3:0] rd,
                                      input logic [3:0] rx, input logic [15:0] off);
    return {op, rd, rx, 2'b00, off};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_store(input logic [15:0] a, input logic [31:0] d, input string tag);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  // monitor: compare every store against the scoreboard
  always @(negedge clk) begin
    if (rst_n && dmem_we && !done) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R12 unexpected store addr", 32'(dmem_addr), 32'd0);
      end else begin
        logic [15:0] ea; logic [31:0] ed; string et;
        ea = q_addr.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
        check(dmem_addr == ea, {et, " store address"}, 32'(dmem_addr), 32'(ea));
        check(dmem_wdata == ed, {et, " store data"}, dmem_wdata, ed);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = enc(K_ST, 4'd15, 4'd0, 16'd30);   // guard word
      dmem[i] = 32'd0;
    end
    dmem[10] = 32'd100;
    dmem[11] = 32'd7;
    dmem[12] = 32'hFFFF_FFFB;                      // -5
    dmem[17] = 32'd555;                            // caught if R0 indexed

    imem[0]  = enc(K_LD,   4'd0, 4'd0, 16'd11);    // R0 = 7
    imem[1]  = enc(K_LD,   4'd1, 4'd0, 16'd10);    // R1 = 100 (R3: no index)
    imem[2]  = enc(K_LD,   4'd2, 4'd0, 16'd11);    // R2 = 7
    imem[3]  = enc(K_LD,   4'd3, 4'd2, 16'd3);     // R3 = mem[10] = 100 (R2)
    imem[4]  = enc(K_ADD,  4'd3, 4'd2, 16'd0);     // R3 = 107
    imem[5]  = enc(K_ST,   4'd3, 4'd0, 16'd20);
    imem[6]  = enc(K_SUBM, 4'd3, 4'd0, 16'd11);    // R3 = 100
    imem[7]  = enc(K_ST,   4'd3, 4'd0, 16'd21);
    imem[8]  = enc(K_MOV,  4'd4, 4'd2, 16'd0);     // R4 = 7
    imem[9]  = enc(K_XOR,  4'd4, 4'd1, 16'd0);     // R4 = 99
    imem[10] = enc(K_ST,   4'd4, 4'd2, 16'd15);    // mem[22]
    imem[11] = enc(K_ANDM, 4'd1, 4'd0, 16'd11);    // R1 = 4
    imem[12] = enc(K_OR,   4'd1, 4'd2, 16'd0);     // R1 = 7
    imem[13] = enc(K_ST,   4'd1, 4'd0, 16'd23);
    imem[14] = enc(K_CMP,  4'd2, 4'd1, 16'd0);     // equal
    imem[15] = enc(K_JC,   4'd1, 4'd0, 16'd18);    // taken
    imem[18] = enc(K_CMPM, 4'd3, 4'd0, 16'd12);    // 100 > -5 signed
    imem[19] = enc(K_JC,   4'd2, 4'd0, 16'd22);    // less: not taken
    imem[20] = enc(K_ST,   4'd3, 4'd0, 16'd24);
    imem[21] = enc(K_JC,   4'd4, 4'd0, 16'd24);    // greater: taken
    imem[24] = enc(K_BAL,  4'd5, 4'd0, 16'd28);    // R5 = 25
    imem[25] = enc(K_JA,   4'd0, 4'd2, 16'd32);    // to 39
    imem[28] = enc(K_ST,   4'd5, 4'd0, 16'd25);
    imem[29] = enc(K_JR,   4'd5, 4'd0, 16'd0);     // back to 25
    imem[39] = enc(K_ST,   4'd2, 4'd0, 16'd26);
    imem[40] = enc(K_CMP,  4'd1, 4'd3, 16'd0);     // 7 < 100
    imem[41] = enc(K_JC,   4'd6, 4'd0, 16'd44);    // mask less|greater
    imem[44] = enc(K_JC,   4'd0, 4'd0, 16'd42);    // mask 000: never
    imem[45] = enc(6'h3F,  4'd1, 4'd2, 16'd5);     // undefined opcode
    imem[46] = enc(K_ST,   4'd1, 4'd0, 16'd27);
    imem[47] = enc(K_ST,   4'd14, 4'd0, 16'd28);
    imem[48] = enc(K_JA,   4'd0, 4'd0, 16'd48);    // halt loop

    expect_store(16'd20, 32'd107, "R2 R3 R4 indexed load and add");
    expect_store(16'd21, 32'd100, "R5 subtract memory");
    expect_store(16'd22, 32'd99,  "R4 R6 move xor indexed store");
    expect_store(16'd23, 32'd7,   "R5 and memory then or");
    expect_store(16'd24, 32'd100, "R7 R8 signed compare fallthrough");
    expect_store(16'd25, 32'd25,  "R10 link value");
    expect_store(16'd26, 32'd7,   "R9 register and indexed jump");
    expect_store(16'd27, 32'd7,   "R8 R11 mask and undefined opcode");
    expect_store(16'd28, 32'd0,   "R1 register reset value");

    repeat (3) @(negedge clk);
    // R1 reset state
    check(imem_addr == '0, "R1 fetch address in reset", 32'(imem_addr), 32'd0);
    check(dmem_we == 1'b0, "R1 no store in reset", 32'(dmem_we), 32'd0);
    rst_n = 1'b1;

    repeat (100) @(negedge clk);
    check(q_addr.size() == 0, "R12 all stores seen", 32'(q_addr.size()), 32'd0);
    check(imem_addr == 16'd48, "R9 halt address", 32'(imem_addr), 32'd48);
    check(dmem[30] == 32'd0 && dmem[20] == 32'd107, "R6 memory contents",
          dmem[20], 32'd107);
    finish_run();
  end
endmodule